// File: doc/BRIEF.md
# Tied-Input LUT Signature Auditor

This block watches a stream of configuration records for 4-input lookup tables and raises an alert whenever a record carries the signature of a dormant, switchable Trojan cell. Each record brings a 16-bit truth-table word and a flag that is set when all four table inputs are driven by one net. With the inputs tied, only table entries 0 and 15 can ever be addressed, so the fourteen entries between them are free to hold hidden data. The auditor splits those fourteen bits into two 7-bit action fields. It declares a match when both fields hold one of two parameter codes, "keep" or "flip".

For every accepted record, the block produces a registered report one cycle later. The report holds the alert bit, the record's position in the stream, one flip flag for each end entry, and the effective function of the tied cell before and after the hidden actions would be applied. The block only observes records and never alters a configuration. Two saturating counters keep totals for review: one counts full matches, and the other counts tied records in which only one of the two fields holds a code. A synchronous clear input resets both counters.

Top module: `lutSigAuditor`

## Requirements
- R1: While reset is held, `inReady`, `outValid`, `outAlert` and both counters are 0. From the first clock edge after reset is released, `inReady` is 1, and one record is accepted in every cycle in which `inValid` is 1.
- R2: A record accepted at a clock edge is reported at the next edge: `outValid` is 1 and `outIndex` holds its position in the stream. Positions count from 0 after reset and wrap at 2^IDX_W.
- R3: A record whose `inTied` is 0 never raises `outAlert` and never changes either counter.
- R4: `outAlert` is 1 exactly when the accepted record has `inTied` = 1 and both fields hold the keep code or the flip code. The low field is `inTruth[7:1]` and the high field is `inTruth[14:8]`.
- R5: `outFlipLo` is 1 when an alerting record has the flip code in `inTruth[7:1]`. `outFlipHi` is 1 when an alerting record has the flip code in `inTruth[14:8]`. Both flags are 0 on a report without an alert.
- R6: `outFuncBefore` encodes the tied function of the accepted record from entry 0 (`inTruth[0]`) and entry 15 (`inTruth[15]`). The codes are: 0 = constant 0 (0,0), 1 = constant 1 (1,1), 2 = follows the input (0,1), 3 = inverts the input (1,0).
- R7: `outFuncAfter` uses the same encoding as R6. It is computed after entry 0 is inverted when `outFlipLo` is 1 and entry 15 is inverted when `outFlipHi` is 1. On a report without an alert it equals `outFuncBefore`.
- R8: `matchCount` rises by one at the edge that accepts an alerting record. It holds at 2^CNT_W-1 instead of wrapping.
- R9: `partialCount` rises by one, saturating, at the edge that accepts a tied record in which exactly one field holds a code. Such a record raises no alert.
- R10: `cntClear` sampled 1 at a clock edge sets both counters to 0 at that edge. The clear takes precedence over an increment at the same edge.
- R11: After an edge at which no record was accepted, `outValid` and `outAlert` are 0 and both counters keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | A record is offered |
| inReady | output | 1 | The auditor takes a record in this cycle |
| inTruth | input | 16 | Truth-table word of the record |
| inTied | input | 1 | All four inputs are driven by one net |
| cntClear | input | 1 | Synchronous clear of both counters |
| outValid | output | 1 | A report is present |
| outAlert | output | 1 | The reported record matched the signature |
| outIndex | output | IDX_W | Stream position of the reported record |
| outFlipLo | output | 1 | Hidden action for entry 0 is flip |
| outFlipHi | output | 1 | Hidden action for entry 15 is flip |
| outFuncBefore | output | 2 | Tied function as configured |
| outFuncAfter | output | 2 | Tied function after the hidden actions |
| matchCount | output | CNT_W | Saturating count of alerts |
| partialCount | output | CNT_W | Saturating count of half matches |

## Verification
A counter clear and a counter increment can fall on the same edge, because a matching or half-matching record may be accepted while `cntClear` is high. The bench provokes this case by raising the clear together with an alerting record, and again together with a half-matching record. In both cases it expects the affected counter to read 0 at the next sample, not 1. The bench also keeps `cntClear` high at the moment the saturated match counter is released from 2^CNT_W-1, so that saturation and clear are judged at the same edge.

// File: rtl/lutSigPkg.sv
package lutSigPkg;

  localparam int TT_W    = 16;
  localparam int FIELD_W = (TT_W - 2) / 2;

  typedef enum logic [1:0] {
    FN_ZERO = 2'd0,
    FN_ONE  = 2'd1,
    FN_PASS = 2'd2,
    FN_INV  = 2'd3
  } tiedFn_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadOut;
    logic bumpIdx;
    logic incMatch;
    logic incPartial;
    logic clrCnt;
  } ctrlStrobe_t;

  // classification from datapath to control
  typedef struct packed {
    logic hit;
    logic partial;
  } classify_t;

  function automatic tiedFn_e encodeFn(input logic entryLo, input logic entryHi);
    tiedFn_e fn;
    unique case ({entryLo, entryHi})
      2'b00:   fn = FN_ZERO;
      2'b11:   fn = FN_ONE;
      2'b01:   fn = FN_PASS;
      default: fn = FN_INV;
    endcase
    return fn;
  endfunction

endpackage

// File: rtl/lutSigSatCnt.sv
module lutSigSatCnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count
);

  localparam logic [W-1:0] MAX_VAL = {W{1'b1}};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        count <= '0;
    else if (clr)                     count <= '0;
    else if (inc && count != MAX_VAL) count <= count + 1'b1;
  end

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (count == MAX_VAL && !clr) |=> count == MAX_VAL);

  // R10
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    clr |=> count == '0);

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!clr && !inc) |=> $stable(count));

endmodule

// File: rtl/lutSigCtrl.sv
module lutSigCtrl
  import lutSigPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        cntClear,
  input  classify_t   cls,
  output logic        inReady,
  output logic        outValid,
  output ctrlStrobe_t strb
);

  logic readyQ;
  logic accept;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) readyQ <= 1'b0;
    else       readyQ <= 1'b1;
  end

  assign inReady = readyQ;
  assign accept  = inValid && readyQ;

  always_comb begin
    strb            = '0;
    strb.loadOut    = accept;
    strb.bumpIdx    = accept;
    strb.incMatch   = accept && cls.hit;
    strb.incPartial = accept && cls.partial;
    strb.clrCnt     = cntClear;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= accept;
  end

  // R2
  report_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> outValid);

  // R11
  no_report_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(inValid && inReady) |=> !outValid);

  // R9
  hit_partial_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(cls.hit && cls.partial));

endmodule

// File: rtl/lutSigData.sv
module lutSigData
  import lutSigPkg::*;
#(
  parameter int                 IDX_W     = 16,
  parameter int                 CNT_W     = 16,
  parameter logic [FIELD_W-1:0] KEEP_CODE = 7'h53,
  parameter logic [FIELD_W-1:0] FLIP_CODE = 7'h2C
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [TT_W-1:0]  inTruth,
  input  logic             inTied,
  input  ctrlStrobe_t      strb,
  input  logic             outValid,
  output classify_t        cls,
  output logic             outAlert,
  output logic [IDX_W-1:0] outIndex,
  output logic             outFlipLo,
  output logic             outFlipHi,
  output logic [1:0]       outFuncBefore,
  output logic [1:0]       outFuncAfter,
  output logic [CNT_W-1:0] matchCount,
  output logic [CNT_W-1:0] partialCount
);

  localparam int NUM_FIELDS = 2;

  logic [NUM_FIELDS-1:0] fieldOk;
  logic [NUM_FIELDS-1:0] fieldFlip;

  // field 0 acts on entry 0, field 1 acts on entry 15
  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
    logic [FIELD_W-1:0] fld;
    assign fld          = inTruth[1 + g*FIELD_W +: FIELD_W];
    assign fieldOk[g]   = (fld == KEEP_CODE) || (fld == FLIP_CODE);
    assign fieldFlip[g] = (fld == FLIP_CODE);
  end

  logic    hitNow;
  logic    flipLoNow;
  logic    flipHiNow;
  tiedFn_e fnBefore;
  tiedFn_e fnAfter;

  assign hitNow      = inTied && (&fieldOk);
  assign cls.hit     = hitNow;
  assign cls.partial = inTied && (^fieldOk);
  assign flipLoNow   = hitNow && fieldFlip[0];
  assign flipHiNow   = hitNow && fieldFlip[1];
  assign fnBefore    = encodeFn(inTruth[0], inTruth[TT_W-1]);
  assign fnAfter     = encodeFn(inTruth[0] ^ flipLoNow, inTruth[TT_W-1] ^ flipHiNow);

  logic [IDX_W-1:0] idxQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             idxQ <= '0;
    else if (strb.bumpIdx) idxQ <= idxQ + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outAlert      <= 1'b0;
      outIndex      <= '0;
      outFlipLo     <= 1'b0;
      outFlipHi     <= 1'b0;
      outFuncBefore <= '0;
      outFuncAfter  <= '0;
    end else if (strb.loadOut) begin
      outAlert      <= hitNow;
      outIndex      <= idxQ;
      outFlipLo     <= flipLoNow;
      outFlipHi     <= flipHiNow;
      outFuncBefore <= fnBefore;
      outFuncAfter  <= fnAfter;
    end else begin
      outAlert      <= 1'b0;
    end
  end

  lutSigSatCnt #(.W(CNT_W)) u_matchCnt (
    .clk   (clk),
    .rstN  (rstN),
    .clr   (strb.clrCnt),
    .inc   (strb.incMatch),
    .count (matchCount)
  );

  lutSigSatCnt #(.W(CNT_W)) u_partialCnt (
    .clk   (clk),
    .rstN  (rstN),
    .clr   (strb.clrCnt),
    .inc   (strb.incPartial),
    .count (partialCount)
  );

  // R3
  untied_silent_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadOut && !inTied) |=> !outAlert);

  // R4
  alert_needs_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    outAlert |-> outValid);

  // R5
  flags_need_alert_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outAlert) |-> (!outFlipLo && !outFlipHi));

  // R7
  keep_unchanged_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outFlipLo && !outFlipHi) |-> outFuncAfter == outFuncBefore);

endmodule

// File: rtl/lutSigAuditor.sv
module lutSigAuditor
  import lutSigPkg::*;
#(
  parameter int                 IDX_W     = 16,
  parameter int                 CNT_W     = 16,
  parameter logic [FIELD_W-1:0] KEEP_CODE = 7'h53,
  parameter logic [FIELD_W-1:0] FLIP_CODE = 7'h2C
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  output logic             inReady,
  input  logic [15:0]      inTruth,
  input  logic             inTied,
  input  logic             cntClear,
  output logic             outValid,
  output logic             outAlert,
  output logic [IDX_W-1:0] outIndex,
  output logic             outFlipLo,
  output logic             outFlipHi,
  output logic [1:0]       outFuncBefore,
  output logic [1:0]       outFuncAfter,
  output logic [CNT_W-1:0] matchCount,
  output logic [CNT_W-1:0] partialCount
);

  ctrlStrobe_t strb;
  classify_t   cls;

  lutSigCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .cntClear (cntClear),
    .cls      (cls),
    .inReady  (inReady),
    .outValid (outValid),
    .strb     (strb)
  );

  lutSigData #(
    .IDX_W     (IDX_W),
    .CNT_W     (CNT_W),
    .KEEP_CODE (KEEP_CODE),
    .FLIP_CODE (FLIP_CODE)
  ) u_data (
    .clk           (clk),
    .rstN          (rstN),
    .inTruth       (inTruth),
    .inTied        (inTied),
    .strb          (strb),
    .outValid      (outValid),
    .cls           (cls),
    .outAlert      (outAlert),
    .outIndex      (outIndex),
    .outFlipLo     (outFlipLo),
    .outFlipHi     (outFlipHi),
    .outFuncBefore (outFuncBefore),
    .outFuncAfter  (outFuncAfter),
    .matchCount    (matchCount),
    .partialCount  (partialCount)
  );

  // R1
  ready_after_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> inReady);

endmodule

// File: tb/lutSigAuditor_bench.sv
module lutSigAuditor_bench;

  localparam int         IDX_W = 16;
  localparam int         CNT_W = 16;
  localparam logic [6:0] KEEP  = 7'h53;
  localparam logic [6:0] FLIP  = 7'h2C;
  localparam int         CMAX  = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             inValid = 1'b0;
  logic             inReady;
  logic [15:0]      inTruth = '0;
  logic             inTied = 1'b0;
  logic             cntClear = 1'b0;
  logic             outValid;
  logic             outAlert;
  logic [IDX_W-1:0] outIndex;
  logic             outFlipLo;
  logic             outFlipHi;
  logic [1:0]       outFuncBefore;
  logic [1:0]       outFuncAfter;
  logic [CNT_W-1:0] matchCount;
  logic [CNT_W-1:0] partialCount;

  always #4 clk = ~clk;

  lutSigAuditor #(
    .IDX_W(IDX_W), .CNT_W(CNT_W), .KEEP_CODE(KEEP), .FLIP_CODE(FLIP)
  ) u_lutSigAuditor (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inTruth(inTruth), .inTied(inTied), .cntClear(cntClear),
    .outValid(outValid), .outAlert(outAlert), .outIndex(outIndex),
    .outFlipLo(outFlipLo), .outFlipHi(outFlipHi),
    .outFuncBefore(outFuncBefore), .outFuncAfter(outFuncAfter),
    .matchCount(matchCount), .partialCount(partialCount)
  );

  int checks = 0;
  int errors = 0;
  int accCount = 0;
  int eMatch = 0;
  int ePart = 0;
  bit finished = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int fnCode(input bit b0, input bit b15);
    if (b0 == b15) return b0 ? 1 : 0;
    return b15 ? 2 : 3;
  endfunction

  function automatic bit isCode(input logic [6:0] f);
    return (f == KEEP) || (f == FLIP);
  endfunction

  // drive at a falling edge, check at the next falling edge
  task automatic step(input bit v, input logic [15:0] t, input bit ti, input bit c);
    bit hit, part, fl, fh;
    int eIdx, eBef, eAft;
    inValid = v; inTruth = t; inTied = ti; cntClear = c;
    hit  = ti && isCode(t[7:1]) && isCode(t[14:8]);
    part = ti && (isCode(t[7:1]) != isCode(t[14:8]));
    fl   = hit && (t[7:1] == FLIP);
    fh   = hit && (t[14:8] == FLIP);
    eBef = fnCode(t[0], t[15]);
    eAft = fnCode(t[0] ^ fl, t[15] ^ fh);
    eIdx = accCount % (1 << IDX_W);
    if (v) accCount++;
    if (c) begin
      eMatch = 0; ePart = 0;
    end else if (v) begin
      if (hit && eMatch < CMAX) eMatch++;
      if (part && ePart < CMAX) ePart++;
    end
    @(negedge clk);
    if (v) begin
      chk("R2 valid", outValid, 1);
      chk("R2 index", outIndex, eIdx);
      chk(ti ? "R4 alert" : "R3 alert", outAlert, hit);
      chk("R5 flipLo", outFlipLo, fl);
      chk("R5 flipHi", outFlipHi, fh);
      chk("R6 before", outFuncBefore, eBef);
      chk("R7 after", outFuncAfter, eAft);
    end else begin
      chk("R11 valid", outValid, 0);
      chk("R11 alert", outAlert, 0);
    end
    chk(c ? "R10 match" : "R8 match", matchCount, eMatch);
    chk(c ? "R10 partial" : "R9 partial", partialCount, ePart);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 ready", inReady, 0);
    chk("R1 valid", outValid, 0);
    chk("R1 alert", outAlert, 0);
    chk("R1 match", matchCount, 0);
    chk("R1 partial", partialCount, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 ready", inReady, 1);

    // exhaustive sweep of tied records
    for (int w = 0; w < 65536; w++) step(1'b1, 16'(w), 1'b1, 1'b0);

    // untied records, including ones holding the signature (R3)
    for (int w = 0; w < 256; w++) begin
      step(1'b1, {w[0], FLIP, KEEP, w[1]}, 1'b0, 1'b0);
      step(1'b1, 16'(w * 257), 1'b0, 1'b0);
    end

    // idle gaps (R11)
    step(1'b0, {1'b1, KEEP, FLIP, 1'b0}, 1'b1, 1'b0);
    step(1'b0, '0, 1'b0, 1'b0);
    step(1'b1, {1'b0, FLIP, FLIP, 1'b0}, 1'b1, 1'b0);
    step(1'b0, '0, 1'b0, 1'b0);

    // clear colliding with a match and with a half match (R10)
    step(1'b1, {1'b1, KEEP, FLIP, 1'b1}, 1'b1, 1'b1);
    step(1'b1, {1'b1, KEEP, 7'h00, 1'b1}, 1'b1, 1'b0);
    step(1'b1, {1'b0, 7'h7F, FLIP, 1'b1}, 1'b1, 1'b1);
    step(1'b1, {1'b0, 7'h7F, FLIP, 1'b1}, 1'b1, 1'b0);

    // saturation of the match counter (R8)
    step(1'b0, '0, 1'b0, 1'b1);
    for (int n = 0; n < CMAX + 5; n++)
      step(1'b1, {n[0], (n[1] ? FLIP : KEEP), (n[2] ? FLIP : KEEP), n[3]}, 1'b1, 1'b0);
    chk("R8 saturated", matchCount, CMAX);
    step(1'b1, {1'b0, KEEP, KEEP, 1'b0}, 1'b1, 1'b1);
    step(1'b1, {1'b0, KEEP, KEEP, 1'b0}, 1'b1, 1'b0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule